// File: doc/BRIEF.md
# Multi-Write Multi-Read Memory with Last-Writer Steering

This block behaves as one small RAM with several independent write ports and several independent read ports. Every port can be used in every clock cycle with no stalls. Inside, each write port owns a private bank of storage. A bank holds one simple dual-port array for each read port, and that write port writes all of them together. Each read port therefore has its own copy of every bank to read from.

A narrow table built from flip-flops has one entry per address. Each entry stores only the index of the write port that last wrote that address. On a read, the registered table entry chooses which bank's copy supplies the data for that read port. The banks are read synchronously, and the table lookup is registered to match. Read data appears on the cycle after the address is presented.

A client connects M producers to the write ports and N consumers to the read ports. It then treats the block as a plain memory with a one-cycle read latency.

Top module: `lvt_mpram`

## Requirements
- R1: After reset every storage location reads as zero on every read port, and all read outputs are zero.
- R2: Data written by any write port to address A is returned by any read port that presents A on a later cycle. The data appears on the read output one clock after the read address is sampled.
- R3: All read ports work independently in the same cycle. Read port r returns the word at its own address, on bits [r*DATA_W +: DATA_W] of the read data bus.
- R4: Writes from different write ports to different addresses in the same cycle all take effect.
- R5: The value read at an address is the value of the most recent write to it, whichever port made that write.
- R6: When several write ports write the same address in the same cycle, the port with the highest index wins. Later reads return that port's data.
- R7: A read of an address that is being written in the same cycle returns the value stored before that write (read-before-write). The new value is returned from the following cycle on.
- R8: A write port whose enable bit is low changes nothing, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | N_WR | Write enable, bit w for write port w |
| wr_addr_i | input | N_WR*ADDR_W | Write addresses, port w at [w*ADDR_W +: ADDR_W] |
| wr_data_i | input | N_WR*DATA_W | Write data, port w at [w*DATA_W +: DATA_W] |
| rd_addr_i | input | N_RD*ADDR_W | Read addresses, port r at [r*ADDR_W +: ADDR_W] |
| rd_data_o | output | N_RD*DATA_W | Read data, port r at [r*DATA_W +: DATA_W], valid one cycle after the address |

## Verification
The first stimulus is a fixed sequence of write and read patterns. It covers writes by a single port, by both ports to separate addresses, and by both ports to one address, with each read port looking at a different location. This shows that the bank choice is made per address and per read port, and not shared across ports. Directed cases then isolate three behaviours: a later writer overriding an earlier one, the same-cycle collision where the higher index must win, and a read colliding with a write, which must see the old value. A long run of random concurrent traffic follows. It is confined to four addresses so that collisions happen often, and every read is compared against a plain behavioural multiport array model.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    // Width of a write-port index stored in the last-writer table.
    function automatic int id_width(input int n_wr);
        return (n_wr > 1) ? $clog2(n_wr) : 1;
    endfunction

endpackage

// File: rtl/lvt_sdp.sv
// One simple dual-port array: a single write port and a single synchronous read port.
module lvt_sdp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rd;
    } sdp_state_t;

    sdp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Read the stored value before this cycle's write lands (read-before-write).
        st_d.rd = st_q.mem[raddr_i];
        if (we_i) begin
            st_d.mem[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rd;

    // R2: a write lands in the array on the next edge
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> st_q.mem[$past(waddr_i)] == $past(wdata_i));

    // R7: colliding read sees the pre-write contents
    assert_read_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (waddr_i == raddr_i)) |=> rdata_o == $past(st_q.mem[raddr_i]));

endmodule

// File: rtl/lvt_bank.sv
// Bank owned by one write port: one array replica per read port, all written together.
module lvt_bank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int N_RD   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        waddr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [N_RD*ADDR_W-1:0]   raddr_i,
    output logic [N_RD*DATA_W-1:0]   rdata_o
);
    for (genvar r = 0; r < N_RD; r++) begin : g_replica
        lvt_sdp #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_sdp (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (we_i),
            .waddr_i (waddr_i),
            .wdata_i (wdata_i),
            .raddr_i (raddr_i[r*ADDR_W +: ADDR_W]),
            .rdata_o (rdata_o[r*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/lvt_table.sv
// Register-based table of last-writer indices, M writes and N registered reads per cycle.
module lvt_table #(
    parameter int ADDR_W = 4,
    parameter int N_WR   = 2,
    parameter int N_RD   = 4,
    parameter int ID_W   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_WR-1:0]        we_i,
    input  logic [N_WR*ADDR_W-1:0] waddr_i,
    input  logic [N_RD*ADDR_W-1:0] raddr_i,
    output logic [N_RD*ID_W-1:0]   sel_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] tbl;
        logic [N_RD-1:0][ID_W-1:0]  sel;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Registered lookup of the pre-write entries, aligned with the bank read.
        for (int r = 0; r < N_RD; r++) begin
            st_d.sel[r] = st_q.tbl[raddr_i[r*ADDR_W +: ADDR_W]];
        end
        // Ascending order: a higher-indexed port overwrites a lower one on collision.
        for (int w = 0; w < N_WR; w++) begin
            if (we_i[w]) begin
                st_d.tbl[waddr_i[w*ADDR_W +: ADDR_W]] = ID_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

    // Checker logic: does a higher-indexed enabled port hit the same address?
    logic [N_WR-1:0] hi_hit;
    always_comb begin
        hi_hit = '0;
        for (int w = 0; w < N_WR; w++) begin
            for (int h = w + 1; h < N_WR; h++) begin
                if (we_i[h] && (waddr_i[h*ADDR_W +: ADDR_W] == waddr_i[w*ADDR_W +: ADDR_W])) begin
                    hi_hit[w] = 1'b1;
                end
            end
        end
    end

    for (genvar w = 0; w < N_WR; w++) begin : g_chk
        localparam logic [ID_W-1:0] WID = ID_W'(w);
        // R6: surviving writer's index is recorded
        assert_last_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i[w] && !hi_hit[w]) |=> st_q.tbl[$past(waddr_i[w*ADDR_W +: ADDR_W])] == WID);
    end

    // R8: no enabled write leaves the table untouched
    assert_tbl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i == '0) |=> $stable(st_q.tbl));

endmodule

// File: rtl/lvt_rdmux.sv
// Per-read-port bank selection driven by the registered table lookup.
module lvt_rdmux #(
    parameter int DATA_W = 8,
    parameter int N_WR   = 2,
    parameter int N_RD   = 4,
    parameter int ID_W   = 1
) (
    input  logic [N_WR*N_RD*DATA_W-1:0] bank_data_i,
    input  logic [N_RD*ID_W-1:0]        sel_i,
    output logic [N_RD*DATA_W-1:0]      rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < N_RD; r++) begin
            for (int w = 0; w < N_WR; w++) begin
                if (sel_i[r*ID_W +: ID_W] == ID_W'(w)) begin
                    rdata_o[r*DATA_W +: DATA_W] = bank_data_i[(w*N_RD + r)*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/lvt_mpram.sv
module lvt_mpram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int N_WR   = 2,
    parameter int N_RD   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_WR-1:0]        wr_en_i,
    input  logic [N_WR*ADDR_W-1:0] wr_addr_i,
    input  logic [N_WR*DATA_W-1:0] wr_data_i,
    input  logic [N_RD*ADDR_W-1:0] rd_addr_i,
    output logic [N_RD*DATA_W-1:0] rd_data_o
);
    localparam int ID_W = lvt_pkg::id_width(N_WR);

    logic [N_WR*N_RD*DATA_W-1:0] bank_rd;
    logic [N_RD*ID_W-1:0]        sel;

    for (genvar w = 0; w < N_WR; w++) begin : g_bank
        lvt_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .N_RD   (N_RD)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (wr_en_i[w]),
            .waddr_i (wr_addr_i[w*ADDR_W +: ADDR_W]),
            .wdata_i (wr_data_i[w*DATA_W +: DATA_W]),
            .raddr_i (rd_addr_i),
            .rdata_o (bank_rd[w*N_RD*DATA_W +: N_RD*DATA_W])
        );
    end

    lvt_table #(
        .ADDR_W (ADDR_W),
        .N_WR   (N_WR),
        .N_RD   (N_RD),
        .ID_W   (ID_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .waddr_i (wr_addr_i),
        .raddr_i (rd_addr_i),
        .sel_o   (sel)
    );

    lvt_rdmux #(
        .DATA_W (DATA_W),
        .N_WR   (N_WR),
        .N_RD   (N_RD),
        .ID_W   (ID_W)
    ) u_mux (
        .bank_data_i (bank_rd),
        .sel_i       (sel),
        .rdata_o     (rd_data_o)
    );

    // R1: outputs are zero on the first cycle out of reset
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> rd_data_o == '0);

endmodule

// File: tb/sim_lvt_mpram.sv
module sim_lvt_mpram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 2;
    localparam int NR = 4;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NW-1:0]     wr_en = '0;
    logic [NW*AW-1:0]  wr_addr = '0;
    logic [NW*DW-1:0]  wr_data = '0;
    logic [NR*AW-1:0]  rd_addr = '0;
    logic [NR*DW-1:0]  rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [DW-1:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lvt_mpram #(.ADDR_W(AW), .DATA_W(DW), .N_WR(NW), .N_RD(NR)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // Vector: {we[1:0], a0, d0, a1, d1, r3, r2, r1, r0}
    localparam int VW = 2 + 2*(AW+DW) + NR*AW;
    localparam int NV = 10;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b01, 4'h1, 8'h10, 4'h0, 8'h00, 4'h3, 4'h2, 4'h1, 4'h0},
        {2'b10, 4'h0, 8'h00, 4'h2, 8'h20, 4'h2, 4'h1, 4'h2, 4'h1},
        {2'b11, 4'h4, 8'h44, 4'h5, 8'h55, 4'h5, 4'h4, 4'h2, 4'h1},
        {2'b00, 4'h4, 8'hEE, 4'h5, 8'hEE, 4'h4, 4'h5, 4'h4, 4'h5},
        {2'b11, 4'h6, 8'h61, 4'h6, 8'h62, 4'h1, 4'h2, 4'h4, 4'h5},
        {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'h6, 4'h6, 4'h6, 4'h6},
        {2'b01, 4'h2, 8'h71, 4'h0, 8'h00, 4'h2, 4'h1, 4'h6, 4'h2},
        {2'b10, 4'h0, 8'h00, 4'h1, 8'h72, 4'h1, 4'h2, 4'h1, 4'h2},
        {2'b11, 4'hF, 8'hF0, 4'hE, 8'hE1, 4'hF, 4'hE, 4'h1, 4'h2},
        {2'b00, 4'h0, 8'h00, 4'h0, 8'h00, 4'hE, 4'hF, 4'hE, 4'hF}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp_v, input int port);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s read port %0d: actual %02h expected %02h", req, port, act, exp_v);
        end
    endtask

    // One cycle: drive at the falling edge, predict from the model before writes, compare after the edge.
    task automatic step(input logic [NW-1:0] we, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                        input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                        input logic [NR*AW-1:0] ra, input string req);
        logic [DW-1:0] exp_v [NR];
        wr_en   = we;
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        rd_addr = ra;
        for (int r = 0; r < NR; r++) exp_v[r] = model[ra[r*AW +: AW]];
        if (we[0]) model[a0] = d0;
        if (we[1]) model[a1] = d1;
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < NR; r++) check(req, rd_data[r*DW +: DW], exp_v[r], r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        for (int r = 0; r < NR; r++) check("R1", rd_data[r*DW +: DW], 8'h00, r);
        rst_n = 1'b1;

        // R1: every location reads zero after reset
        step(2'b00, 0, 0, 0, 0, {4'hF, 4'hA, 4'h5, 4'h0}, "R1");

        // Vector table: mixed single, dual and colliding writes, per-port reads (R2, R3, R4)
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            step(e[VW-1 -: 2], e[VW-3 -: AW], e[VW-3-AW -: DW],
                 e[VW-3-AW-DW -: AW], e[VW-3-2*AW-DW -: DW], e[NR*AW-1:0], "R2_R3_R4");
        end

        // R5: later writer overrides, either direction
        step(2'b01, 4'h9, 8'h33, 0, 0, {4{4'h9}}, "R5");
        step(2'b10, 0, 0, 4'h9, 8'h44, {4{4'h9}}, "R5");
        step(2'b01, 4'h9, 8'h55, 0, 0, {4{4'h9}}, "R5");
        step(2'b00, 0, 0, 0, 0, {4{4'h9}}, "R5");
        check("R5", rd_data[7:0], 8'h55, 0);

        // R6: same-address collision, higher port wins
        step(2'b11, 4'hB, 8'hAA, 4'hB, 8'hBB, {4{4'hB}}, "R6");
        step(2'b00, 0, 0, 0, 0, {4{4'hB}}, "R6");
        check("R6", rd_data[31:24], 8'hBB, 3);

        // R7: read colliding with write returns old value, then new
        step(2'b01, 4'h9, 8'h66, 0, 0, {4{4'h9}}, "R7");
        check("R7", rd_data[15:8], 8'h55, 1);
        step(2'b00, 0, 0, 0, 0, {4{4'h9}}, "R7");
        check("R7", rd_data[23:16], 8'h66, 2);

        // R8: disabled write ports change nothing
        step(2'b00, 4'h9, 8'h99, 4'hB, 8'h99, {4'hB, 4'h9, 4'hB, 4'h9}, "R8");
        step(2'b00, 0, 0, 0, 0, {4'hB, 4'h9, 4'hB, 4'h9}, "R8");
        check("R8", rd_data[7:0], 8'h66, 0);
        check("R8", rd_data[15:8], 8'hBB, 1);

        // Random concurrent traffic on four addresses to force collisions (R5, R6, R7)
        for (int k = 0; k < 400; k++) begin
            step(NW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)), DW'($urandom),
                 AW'($urandom_range(0, 3)), DW'($urandom),
                 {AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3))}, "R5_R6_R7_random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule